// File: doc/BRIEF.md
# Block-Write Control Register Slave

This block is a two-wire serial slave that only accepts block writes. It fills a small bank of 8-bit control registers from the data bytes of each write. SCL and SDA are sampled by a fast system clock through a synchronizer. START and STOP are detected from SDA edges while SCL is high. The serial clock is never stretched, and the block never takes part in arbitration.

The slave address comes from a lookup on three strap inputs. After the address and write bit, the master sends a command code, which must be 0x00 for a block operation. A byte count follows, and then the data bytes. Register 0 receives the first data byte, register 1 the next, and so on. The master may stop after any complete byte, and every register already written keeps its new value. The block pulls SDA low through an open-drain enable to acknowledge a byte. Its other outputs are the register contents, flattened with register 0 in the lowest byte.

Top module: `smb_blkwr_regs`

## Requirements
- R1: After reset the registers hold reg0 = 0xA1, reg1 = 0xFF and reg2 = 0xFF, and `sda_pull_o` is 0.
- R2: The strap input `strap_i` = {s2,s1,s0} selects the 8-bit write address: 000→0xDE, 001→0xDC, 010→0xDA, 011→0xD8, 100→0xD6, 101→0xD4, 110→0xD0, 111→0xD2. An address byte equal to this value (R/W bit 0 in bit 0) is acknowledged.
- R3: An address byte that matches in bits 7:1 but has bit 0 = 1 (read) is not acknowledged, and later bytes are not acknowledged either.
- R4: The command code, the second byte, must be 0x00. Any other value is not acknowledged, and no register changes until the next START.
- R5: Bytes are received most significant bit first. The data bytes that follow the byte count are written to reg0, reg1 and reg2 in that order, and each one is acknowledged.
- R6: An acknowledge pulls SDA low only while SCL is low after the eighth bit. The pull is held through the ninth SCL high phase and released after the ninth SCL falling edge.
- R7: A STOP after any complete byte ends the transfer. Registers written before it keep their new values, and the remaining registers are untouched.
- R8: Data bytes past the byte count, or past reg2, are acknowledged and discarded.
- R9: A START in the middle of a transfer, even part-way through a byte, discards the partial byte and restarts the address phase.
- R10: An address byte that differs from the strapped address is not acknowledged, and the block ignores the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Address strap {s2,s1,s0} |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain enable) |
| regs_o | output | 24 | Register contents, reg0 in bits 7:0 |

## Verification
A wrong phase or bit counter shows up within one byte time. The acknowledge bit appears on the wrong clock or not at all, or the data lands in a register shifted by one bit. A wrong data index or count shows on `regs_o` right after the ninth clock of the affected data byte, as a neighbouring register changing or a discarded byte being stored. A stuck pull shows at the next SCL high phase, because the master then reads a false acknowledge on a byte that should be refused.

// File: rtl/smbw_pkg.sv
package smbw_pkg;
   localparam int         BYTE_W    = 8;
   localparam logic [7:0] CMD_BLOCK = 8'h00;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_DATA, ST_SKIP
   } smbw_state_e;

   typedef enum logic [1:0] {
      PH_BITS, PH_WAIT, PH_ACK
   } smbw_phase_e;
endpackage

// File: rtl/smbw_sync.sv
module smbw_sync #(
   parameter int STAGES = 2,
   parameter int LINES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] raw_i,
   output logic [LINES-1:0] sync_o,
   output logic [LINES-1:0] rise_o,
   output logic [LINES-1:0] fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("smbw_sync: STAGES must be at least 2");
   end

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [STAGES-1:0] chain;
      logic              prev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
         end else begin
            chain <= {chain[STAGES-2:0], raw_i[l]};
            prev  <= chain[STAGES-1];
         end
      end
      assign sync_o[l] = chain[STAGES-1];
      assign rise_o[l] = chain[STAGES-1] & ~prev;
      assign fall_o[l] = ~chain[STAGES-1] & prev;
   end
endmodule

// File: rtl/smbw_addr_map.sv
module smbw_addr_map (
   input  logic [2:0] strap_i,
   output logic [7:0] addr_o
);
   always_comb begin
      case (strap_i)
         3'b000:  addr_o = 8'hDE;
         3'b001:  addr_o = 8'hDC;
         3'b010:  addr_o = 8'hDA;
         3'b011:  addr_o = 8'hD8;
         3'b100:  addr_o = 8'hD6;
         3'b101:  addr_o = 8'hD4;
         3'b110:  addr_o = 8'hD0;
         default: addr_o = 8'hD2;
      endcase
   end
endmodule

// File: rtl/smbw_engine.sv
module smbw_engine
   import smbw_pkg::*;
#(
   parameter int NREG = 3,
   localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sda_s,
   input  logic            scl_up,
   input  logic            scl_dn,
   input  logic            start_p,
   input  logic            stop_p,
   input  logic [7:0]      own_addr,
   output logic            pull_o,
   output logic            wr_en,
   output logic [IDXW-1:0] wr_idx,
   output logic [7:0]      wr_data
);
   localparam logic [7:0] NREG_B = 8'(NREG);

   smbw_state_e st;
   smbw_phase_e ph;
   logic [2:0]  bitcnt;
   logic [6:0]  shreg;
   logic [7:0]  cnt;
   logic [7:0]  didx;
   logic [7:0]  byte_now;
   logic        byte_done;
   logic        accept;

   assign byte_now  = {shreg, sda_s};
   assign byte_done = scl_up && (ph == PH_BITS) && (bitcnt == 3'd7) &&
                      (st != ST_IDLE) && (st != ST_SKIP);

   always_comb begin
      case (st)
         ST_ADDR: accept = (byte_now == own_addr);
         ST_CMD:  accept = (byte_now == CMD_BLOCK);
         ST_CNT,
         ST_DATA: accept = 1'b1;
         default: accept = 1'b0;
      endcase
   end

   assign wr_en   = byte_done && (st == ST_DATA) && (didx < NREG_B) && (didx < cnt);
   assign wr_idx  = didx[IDXW-1:0];
   assign wr_data = byte_now;

   function automatic smbw_state_e after_ack(smbw_state_e s);
      case (s)
         ST_ADDR: return ST_CMD;
         ST_CMD:  return ST_CNT;
         ST_CNT:  return ST_DATA;
         ST_DATA: return ST_DATA;
         default: return ST_SKIP;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ph     <= PH_BITS;
         bitcnt <= '0;
         shreg  <= '0;
         cnt    <= '0;
         didx   <= '0;
         pull_o <= 1'b0;
      end else if (start_p) begin
         st     <= ST_ADDR;
         ph     <= PH_BITS;
         bitcnt <= '0;
         pull_o <= 1'b0;
      end else if (stop_p) begin
         st     <= ST_IDLE;
         ph     <= PH_BITS;
         bitcnt <= '0;
         pull_o <= 1'b0;
      end else begin
         case (ph)
            PH_BITS: begin
               if (scl_up && st != ST_IDLE && st != ST_SKIP) begin
                  shreg  <= byte_now[6:0];
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) begin
                     if (accept) begin
                        ph <= PH_WAIT;
                        case (st)
                           ST_ADDR: didx <= '0;
                           ST_CNT:  cnt  <= byte_now;
                           ST_DATA: if (didx != 8'hFF) didx <= didx + 8'd1;
                           default: ;
                        endcase
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
            end
            PH_WAIT: begin
               if (scl_dn) begin
                  pull_o <= 1'b1;
                  ph     <= PH_ACK;
               end
            end
            default: begin
               if (scl_dn) begin
                  pull_o <= 1'b0;
                  ph     <= PH_BITS;
                  bitcnt <= '0;
                  st     <= after_ack(st);
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/smbw_regbank.sv
module smbw_regbank #(
   parameter int              NREG     = 3,
   parameter logic [NREG*8-1:0] RST_VALS = '1,
   localparam int             IDXW     = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDXW-1:0]   wr_idx,
   input  logic [7:0]        wr_data,
   output logic [NREG*8-1:0] regs_o
);
   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_o[g*8 +: 8] <= RST_VALS[g*8 +: 8];
         else if (wr_en && wr_idx == IDXW'(g))
            regs_o[g*8 +: 8] <= wr_data;
      end
   end
endmodule

// File: rtl/smb_blkwr_regs.sv
module smb_blkwr_regs #(
   parameter int                NREG        = 3,
   parameter int                SYNC_STAGES = 2,
   parameter logic [NREG*8-1:0] RST_VALS    = {8'hFF, 8'hFF, 8'hA1},
   localparam int               IDXW        = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [2:0]        strap_i,
   output logic              sda_pull_o,
   output logic [NREG*8-1:0] regs_o
);
   if (NREG < 1 || NREG > 255) begin : g_bad_nreg
      $error("smb_blkwr_regs: NREG must be 1..255");
   end

   logic [1:0] s_sync, s_rise, s_fall;
   logic       scl_s, sda_s, scl_up, scl_dn, start_p, stop_p;
   logic [7:0] own_addr;
   logic            wr_en;
   logic [IDXW-1:0] wr_idx;
   logic [7:0]      wr_data;

   smbw_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_i({sda_i, scl_i}),
      .sync_o(s_sync), .rise_o(s_rise), .fall_o(s_fall)
   );

   assign scl_s   = s_sync[0];
   assign sda_s   = s_sync[1];
   assign scl_up  = s_rise[0];
   assign scl_dn  = s_fall[0];
   assign start_p = s_fall[1] & scl_s;
   assign stop_p  = s_rise[1] & scl_s;

   smbw_addr_map u_amap (.strap_i(strap_i), .addr_o(own_addr));

   smbw_engine #(.NREG(NREG)) u_eng (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_up(scl_up), .scl_dn(scl_dn),
      .start_p(start_p), .stop_p(stop_p), .own_addr(own_addr),
      .pull_o(sda_pull_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   smbw_regbank #(.NREG(NREG), .RST_VALS(RST_VALS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .regs_o(regs_o)
   );
endmodule

// File: rtl/smbw_chk.sv
module smbw_chk #(
   parameter int NREG = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              scl_up,
   input logic              start_p,
   input logic              stop_p,
   input logic              sda_pull_o,
   input logic [NREG*8-1:0] regs_o
);
   // R6: the acknowledge pull begins only while SCL is low
   assert_pull_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> !scl_s);
   // R6: the pull ends only while SCL is low
   assert_release_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull_o) |-> !scl_s);
   // R9: a START leaves SDA released
   assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> !sda_pull_o);
   // R7: a STOP leaves SDA released
   assert_stop_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> !sda_pull_o);
   // R5: registers change only on a sampled SCL rising edge
   assert_write_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !scl_up |=> $stable(regs_o));
endmodule

bind smb_blkwr_regs smbw_chk #(.NREG(NREG)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_up(scl_up),
   .start_p(start_p), .stop_p(stop_p), .sda_pull_o(sda_pull_o), .regs_o(regs_o)
);

// File: tb/sim_smb_blkwr_regs.sv
module sim_smb_blkwr_regs;
   localparam int Q = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic [2:0]  strap = 3'b000;
   logic        sda_pull;
   logic [23:0] regs;
   logic        sda_line;
   int          checks = 0;
   int          errors = 0;
   logic [7:0]  e0, e1, e2;

   always #2.5 clk = ~clk;

   assign sda_line = m_sda & ~sda_pull;

   smb_blkwr_regs u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .strap_i(strap), .sda_pull_o(sda_pull), .regs_o(regs)
   );

   task automatic check(input logic ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
   endtask

   task automatic bit_out(input logic b);
      m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
   endtask

   task automatic byte_out(input logic [7:0] b, output logic ack,
                           output logic pull_lo, output logic pull_after);
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      m_sda = 1'b1; wq();
      pull_lo = sda_pull;
      m_scl = 1'b1; wq();
      ack = ~sda_line;
      wq(); m_scl = 1'b0; wq();
      pull_after = sda_pull;
   endtask

   // sends n bytes, byte i in bytes[8*i +: 8]; ack of byte i in acks[i]
   task automatic txn(input logic [63:0] bytes, input int n, input logic do_stop,
                      output logic [7:0] acks);
      logic a, pl, pa;
      acks = '0;
      bus_start();
      for (int i = 0; i < n; i++) begin
         byte_out(bytes[8*i +: 8], a, pl, pa);
         acks[i] = a;
      end
      if (do_stop) bus_stop();
   endtask

   function automatic logic [7:0] strap_addr(input logic [2:0] s);
      logic [7:0] t [8];
      t[0] = 8'hDE; t[1] = 8'hDC; t[2] = 8'hDA; t[3] = 8'hD8;
      t[4] = 8'hD6; t[5] = 8'hD4; t[6] = 8'hD0; t[7] = 8'hD2;
      return t[s];
   endfunction

   task automatic check_regs(input string req);
      check(regs == {e2, e1, e0}, req, {8'h0, regs}, {8'h0, e2, e1, e0});
   endtask

   task automatic t_reset();
      e0 = 8'hA1; e1 = 8'hFF; e2 = 8'hFF;
      check_regs("R1 reset values");
      check(sda_pull == 1'b0, "R1 pull idle", {31'h0, sda_pull}, 0);
   endtask

   task automatic t_ack_timing();
      logic a, pl, pa;
      strap = 3'b000;
      bus_start();
      byte_out(strap_addr(3'b000), a, pl, pa);
      check(a == 1'b1, "R2 address ack", {31'h0, a}, 1);
      check(pl == 1'b1, "R6 pull while SCL low", {31'h0, pl}, 1);
      check(pa == 1'b0, "R6 release after ninth clock", {31'h0, pa}, 0);
      bus_stop();
   endtask

   task automatic t_full_write();
      logic [7:0] acks;
      strap = 3'b000;
      txn({16'h0, 8'h56, 8'h34, 8'h12, 8'h03, 8'h00, 8'hDE}, 6, 1'b1, acks);
      check(acks[5:0] == 6'h3F, "R5 all bytes acked", {24'h0, acks}, 32'h3F);
      e0 = 8'h12; e1 = 8'h34; e2 = 8'h56;
      check_regs("R5 ordered write");
   endtask

   task automatic t_partial();
      logic [7:0] acks;
      strap = 3'b101;
      txn({32'h0, 8'h5A, 8'h03, 8'h00, strap_addr(3'b101)}, 4, 1'b1, acks);
      check(acks[3:0] == 4'hF, "R2 strap 101 ack", {24'h0, acks}, 32'hF);
      e0 = 8'h5A;
      check_regs("R7 stop after one data byte");
      strap = 3'b110;
      txn({24'h0, 8'h3C, 8'hC3, 8'h02, 8'h00, strap_addr(3'b110)}, 5, 1'b1, acks);
      check(acks[4:0] == 5'h1F, "R2 strap 110 ack", {24'h0, acks}, 32'h1F);
      e0 = 8'hC3; e1 = 8'h3C;
      check_regs("R5 two-byte write");
   endtask

   task automatic t_wrong_addr();
      logic [7:0] acks;
      strap = 3'b110;
      txn({32'h0, 8'h77, 8'h01, 8'h00, 8'hDE}, 4, 1'b1, acks);
      check(acks[3:0] == 4'h0, "R10 mismatch not acked", {24'h0, acks}, 0);
      check_regs("R10 nothing written");
   endtask

   task automatic t_read_bit();
      logic [7:0] acks;
      strap = 3'b110;
      txn({32'h0, 8'h77, 8'h01, 8'h00, 8'hD1}, 4, 1'b1, acks);
      check(acks[3:0] == 4'h0, "R3 read not acked", {24'h0, acks}, 0);
      check_regs("R3 nothing written");
   endtask

   task automatic t_bad_cmd();
      logic [7:0] acks;
      strap = 3'b110;
      txn({32'h0, 8'h99, 8'h01, 8'h07, 8'hD0}, 4, 1'b1, acks);
      check(acks[3:0] == 4'h1, "R4 command refused", {24'h0, acks}, 1);
      check_regs("R4 nothing written");
   endtask

   task automatic t_overflow();
      logic [7:0] acks;
      strap = 3'b011;
      txn({16'h0, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02, 8'h00, 8'hD8}, 7, 1'b1, acks);
      check(acks[6:0] == 7'h7F, "R8 bytes past count acked", {24'h0, acks}, 32'h7F);
      e0 = 8'h11; e1 = 8'h22;
      check_regs("R8 bytes past count discarded");
      txn({8'hE0, 8'hD0, 8'hC0, 8'hB0, 8'hA0, 8'h05, 8'h00, 8'hD8}, 8, 1'b1, acks);
      check(acks == 8'hFF, "R8 bytes past reg2 acked", {24'h0, acks}, 32'hFF);
      e0 = 8'hA0; e1 = 8'hB0; e2 = 8'hC0;
      check_regs("R8 bytes past reg2 discarded");
   endtask

   task automatic t_restart();
      logic a, pl, pa;
      logic [7:0] acks;
      strap = 3'b011;
      bus_start();
      byte_out(8'hD8, a, pl, pa);
      byte_out(8'h00, a, pl, pa);
      byte_out(8'h03, a, pl, pa);
      bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
      txn({32'h0, 8'h77, 8'h01, 8'h00, 8'hD8}, 4, 1'b1, acks);
      check(acks[3:0] == 4'hF, "R9 restart acked", {24'h0, acks}, 32'hF);
      e0 = 8'h77;
      check_regs("R9 restart write");
   endtask

   task automatic t_early_stop();
      logic [7:0] acks;
      strap = 3'b011;
      txn({48'h0, 8'h00, 8'hD8}, 2, 1'b1, acks);
      check_regs("R7 stop after command");
      txn({40'h0, 8'h03, 8'h00, 8'hD8}, 3, 1'b1, acks);
      check(acks[2:0] == 3'h7, "R7 header acked", {24'h0, acks}, 7);
      check_regs("R7 stop after count");
      check(sda_pull == 1'b0, "R7 bus released", {31'h0, sda_pull}, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_ack_timing();
      t_full_write();
      t_partial();
      t_wrong_addr();
      t_read_bit();
      t_bad_cmd();
      t_overflow();
      t_restart();
      t_early_stop();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule